// File: doc/BRIEF.md
# Converter Serial Read-Out Port

This block is the digital slave side of a sampling converter's serial read-out. A falling edge on the convert-start input begins a conversion. The block raises a busy flag for a programmable number of system clocks. When busy drops, it loads the converter result from an input port into its output register. The controller then supplies its own serial clock and reads a 16-bit frame, most significant bit first. The frame is two zero pad bits followed by the 14-bit result. The data line is released to high impedance when the frame ends.

The serial clock and convert-start pins are not clocked by the system clock. Each one passes through a two-flop synchronizer and an edge detector, so the system clock must run at least four times faster than the serial clock.

The serial clock may stop low at any point in a frame, for example to read the frame as two bytes. Clock pulses beyond the sixteenth start the frame again from its first bit. A convert-start fall returns the bit position to the start of a frame, but only when the serial clock is low at that moment.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `busy` is 0 and `sdata_oe` is 0, so `sdata` is high impedance.
- R2: A falling edge on `convst_in` sets `busy` to 1. `busy` stays at 1 for exactly `CONV_CYC` system clocks and then returns to 0.
- R3: `result_in` is captured into the output register only when `busy` falls. A change on `result_in` at any other time does not alter the frame that is read.
- R4: A frame holds 16 bit positions. Positions 0 and 1 are 0. Positions 2 to 15 carry result bits 13 down to 0. The position advances on each falling edge of `sclk_in`.
- R5: The first rising `sclk_in` edge of a frame sets `sdata_oe` and presents position 0. Each bit stays valid through the high and the low phase of `sclk_in`.
- R6: After the 16th falling `sclk_in` edge, `sdata_oe` is 0.
- R7: A rising `sclk_in` edge after the 16th fall restarts the frame at position 0 with `sdata_oe` at 1. `sdata_oe` stays at 1 while the clock then stays idle.
- R8: A `convst_in` fall while `sclk_in` is low resets the bit position to 0 and clears `sdata_oe`.
- R9: A `convst_in` fall while `sclk_in` is high leaves the bit position and `sdata_oe` unchanged.
- R10: Holding `sclk_in` low in the middle of a frame, for any length of time, keeps the current bit and position.
- R11: A `convst_in` fall while `busy` is 1 does not restart or extend the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the controller, asynchronous |
| convst_in | input | 1 | Convert start; a falling edge starts a conversion, asynchronous |
| result_in | input | RES_W | Converter result, captured when busy falls |
| busy | output | 1 | High while a conversion is in progress |
| sdata | output | 1 | Serial data; high impedance when sdata_oe is 0 |
| sdata_oe | output | 1 | High while sdata is driven |

## Verification
An edge applied to `sclk_in` or `convst_in` passes through three registers: two synchronizer flops, then the register it acts on. Its effect on `sdata`, `sdata_oe` or `busy` therefore appears within three system clocks.

The bench drives each pin change on a falling system clock edge. It samples four clocks later, also on a falling edge, and drives the next pin change only after that sample. Each half period of `sclk_in` is therefore four system clocks long.

The length of `busy` is measured by counting the falling-edge samples in which `busy` is high. That count must equal `CONV_CYC`.

// File: rtl/adc_port_pkg.sv
// Shared types for the converter serial read-out port.
package adc_port_pkg;

    // Synchronized view of one asynchronous pin
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_edges_t;

endpackage

// File: rtl/pin_edge_sync.sv
// Two-flop synchronizer followed by an edge detector for one asynchronous pin.
// Assumes the pin stays at each level for at least two system clocks.
module pin_edge_sync
    import adc_port_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    output pin_edges_t edges
);
    localparam int unsigned TOT = STAGES + 1;

    logic [TOT-1:0] chain_q;

    // Shift the pin through the synchronizer and one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[TOT-2:0], pin};
    end

    // Compare the synchronized level with the level one clock earlier
    always_comb begin
        edges.level = chain_q[TOT-2];
        edges.rise  = chain_q[TOT-2] & ~chain_q[TOT-1];
        edges.fall  = ~chain_q[TOT-2] & chain_q[TOT-1];
    end
endmodule

// File: rtl/conv_timer.sv
// Models the conversion time. A start pulse raises busy for CONV_CYC clocks.
// A one-cycle done pulse follows the fall of busy. Starts while busy are ignored.
module conv_timer #(
    parameter int unsigned CONV_CYC = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(CONV_CYC + 1);

    logic [CNT_W-1:0] left_q;

    // Count down the conversion and flag its end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            left_q <= '0;
        end else begin
            done <= 1'b0;
            if (!busy && start) begin
                busy   <= 1'b1;
                left_q <= CNT_W'(CONV_CYC - 1);
            end else if (busy) begin
                if (left_q == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    left_q <= left_q - 1'b1;
                end
            end
        end
    end

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && left_q != '0) |=> (busy && left_q == $past(left_q) - 1'b1));
endmodule

// File: rtl/frame_shifter.sv
// Holds the output register and the bit position of the serial frame.
// Selects the current frame bit and controls the output enable.
// Assumes the serial clock edges arrive already synchronized to clk.
module frame_shifter
    import adc_port_pkg::*;
#(
    parameter int unsigned RES_W   = 14,
    parameter int unsigned FRAME_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pin_edges_t       sck,
    input  logic             cv_fall,
    input  logic             load,
    input  logic [RES_W-1:0] result,
    output logic             dout,
    output logic             oe
);
    localparam int unsigned LEAD  = FRAME_W - RES_W;
    localparam int unsigned IDX_W = $clog2(FRAME_W + 1);
    localparam int unsigned POS_W = (RES_W > 1) ? $clog2(RES_W) : 1;

    logic [IDX_W-1:0] idx_q;
    logic [RES_W-1:0] out_q;
    logic [POS_W-1:0] sel;

    // Capture the result and step the frame position on serial clock edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            oe    <= 1'b0;
            out_q <= '0;
        end else begin
            if (load) out_q <= result;
            if (cv_fall && !sck.level) begin
                idx_q <= '0;
                oe    <= 1'b0;
            end else if (sck.rise) begin
                oe <= 1'b1;
                if (idx_q == IDX_W'(FRAME_W)) idx_q <= '0;
            end else if (sck.fall && idx_q < IDX_W'(FRAME_W)) begin
                idx_q <= idx_q + 1'b1;
                if (idx_q == IDX_W'(FRAME_W - 1)) oe <= 1'b0;
            end
        end
    end

    // Pick the frame bit for the current position
    always_comb begin
        sel  = POS_W'(RES_W - 1 + LEAD) - POS_W'(idx_q);
        dout = 1'b0;
        if (idx_q >= IDX_W'(LEAD) && idx_q < IDX_W'(FRAME_W)) dout = out_q[sel];
    end

    // R3
    load_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != $past(out_q)) |-> $past(load));

    // R5
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(sck.rise));

    // R10
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != $past(idx_q)) |-> ($past(sck.rise) || $past(sck.fall) || $past(cv_fall)));

    // R6
    oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> (idx_q == IDX_W'(FRAME_W) || idx_q == '0));
endmodule

// File: rtl/adc_serial_port.sv
// Slave serial read-out port of a sampling converter.
// It synchronizes the serial clock and convert-start pins, times the conversion,
// and shifts out a 16-bit frame with a three-state data line.
// Assumes clk runs at least four times faster than sclk_in.
module adc_serial_port
    import adc_port_pkg::*;
#(
    parameter int unsigned RES_W    = 14,
    parameter int unsigned FRAME_W  = 16,
    parameter int unsigned CONV_CYC = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_in,
    input  logic             convst_in,
    input  logic [RES_W-1:0] result_in,
    output logic             busy,
    output wire              sdata,
    output logic             sdata_oe
);
    pin_edges_t sck_e;
    pin_edges_t cv_e;
    logic       conv_done;
    logic       bit_out;

    pin_edge_sync #(.STAGES(2)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .pin(sclk_in), .edges(sck_e));

    pin_edge_sync #(.STAGES(2)) u_cv_sync (
        .clk(clk), .rst_n(rst_n), .pin(convst_in), .edges(cv_e));

    conv_timer #(.CONV_CYC(CONV_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(cv_e.fall), .busy(busy), .done(conv_done));

    frame_shifter #(.RES_W(RES_W), .FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sck(sck_e), .cv_fall(cv_e.fall),
        .load(conv_done), .result(result_in), .dout(bit_out), .oe(sdata_oe));

    // Release the data line when the frame is not being driven
    assign sdata = sdata_oe ? bit_out : 1'bz;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !sdata_oe));
endmodule

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int CONV       = 24;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b0;
    logic        convst_in = 1'b1;
    logic [13:0] result_in = '0;
    logic        busy;
    wire         sdata;
    logic        sdata_oe;

    int checks = 0;
    int errors = 0;
    int pos = 0;
    logic [13:0] held = '0;

    adc_serial_port #(.RES_W(14), .FRAME_W(16), .CONV_CYC(CONV)) uut (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .convst_in(convst_in),
        .result_in(result_in), .busy(busy), .sdata(sdata), .sdata_oe(sdata_oe));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_bit(logic [13:0] r, int p);
        return (p < 2) ? 1'b0 : r[13 - (p - 2)];
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rise_edge(string tag);
        sclk_in = 1'b1;
        hold(HALF);
        if (pos == 16) pos = 0;
        chk(sdata_oe == 1'b1, tag, "oe after rise", int'(sdata_oe), 1);
        chk(sdata === exp_bit(held, pos), tag, "bit at high phase", int'(sdata), int'(exp_bit(held, pos)));
    endtask

    task automatic fall_edge();
        sclk_in = 1'b0;
        hold(HALF);
        if (pos < 16) pos++;
        if (pos == 16) chk(sdata_oe == 1'b0, "R6", "oe after last fall", int'(sdata_oe), 0);
        else chk(sdata_oe && sdata === exp_bit(held, pos), "R4", "bit at low phase",
                 int'(sdata), int'(exp_bit(held, pos)));
    endtask

    task automatic read_bits(int n);
        for (int i = 0; i < n; i++) begin
            rise_edge(pos == 0 ? "R5" : "R4");
            fall_edge();
        end
    endtask

    task automatic convert(bit mid);
        int cnt = 0;
        convst_in = 1'b0;
        for (int i = 0; i < 4 * CONV + 40; i++) begin
            @(negedge clk);
            if (mid && i == 6)  convst_in = 1'b1;
            if (mid && i == 12) convst_in = 1'b0;
            if (busy) cnt++;
            else if (cnt > 0) break;
        end
        convst_in = 1'b1;
        hold(HALF);
        chk(cnt == CONV, mid ? "R11" : "R2", "busy length", cnt, CONV);
        if (!sclk_in) pos = 0;
        held = result_in;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        hold(4);
        rst_n = 1'b1;
        hold(2);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(sdata_oe == 1'b0, "R1", "oe after reset", int'(sdata_oe), 0);

        // Basic conversion and full frame; R3 capture only at busy fall
        result_in = 14'h2A5C;
        convert(1'b0);
        result_in = 14'h1133;
        read_bits(16);
        chk(sdata_oe == 1'b0, "R6", "idle after frame", int'(sdata_oe), 0);
        read_bits(16);
        chk(held == 14'h2A5C, "R3", "frame kept old result", int'(held), 14'h2A5C);

        // R7 extra clock restarts and stays driven
        rise_edge("R7");
        hold(20);
        chk(sdata_oe == 1'b1 && sdata === 1'b0, "R7", "driven while idle", int'(sdata_oe), 1);
        fall_edge();
        read_bits(15);

        // R10 two-byte read with a long pause
        result_in = 14'h3FFF;
        convert(1'b0);
        read_bits(8);
        hold(30);
        chk(sdata_oe && sdata === exp_bit(held, pos), "R10", "bit kept over pause",
            int'(sdata), int'(exp_bit(held, pos)));
        read_bits(8);

        // R8 convert with sclk low mid-frame
        result_in = 14'h0001;
        convert(1'b0);
        read_bits(6);
        result_in = 14'h2001;
        convert(1'b0);
        chk(sdata_oe == 1'b0, "R8", "oe cleared by convert", int'(sdata_oe), 0);
        read_bits(16);

        // R9 convert with sclk high keeps position
        read_bits(5);
        rise_edge("R4");
        convert(1'b0);
        chk(sdata_oe && sdata === exp_bit(held, pos), "R9", "position kept",
            int'(sdata), int'(exp_bit(held, pos)));
        fall_edge();
        read_bits(10);

        // R11 second convst fall during busy
        result_in = 14'h15A3;
        convert(1'b1);
        read_bits(16);

        // Random frames with random pauses
        for (int k = 0; k < 15; k++) begin
            result_in = 14'($urandom);
            convert(1'b0);
            for (int b = 0; b < 16; b++) begin
                read_bits(1);
                if ($urandom_range(0, 3) == 0) hold($urandom_range(1, 25));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule